// File: doc/BRIEF.md
# Staged Watchdog Timer

The block is a watchdog held in one 32-bit control word on a simple register bus, where a write lands in one clock and a read returns at once. Two 2-bit fields set the timeout. The prescaler code sets how many clocks make one tick. The interval code sets how many ticks make one timeout. The count is measured from the last restart.

When the interval runs out, the block raises an interrupt flag as a warning. It drives the interrupt output only when interrupts are enabled. A fixed number of ticks later, if software has not restarted the count, the block issues a one-cycle system reset request and latches a reset flag. The request is issued only when reset is enabled. Software keeps the system alive by writing the restart bit. The usual way is a read-modify-write that leaves the other fields unchanged.

Top module: `wdog_timer`

## Requirements
- R1: After reset the register reads 0 and both `irq_o` and `rst_req_o` are low.
- R2: Register fields:
  - bit 7 is run enable;
  - bit 6 is interrupt enable;
  - bits 5:4 are the interval code;
  - bit 3 is the interrupt flag;
  - bit 2 is the reset flag;
  - bit 1 is reset enable;
  - bit 0 is restart;
  - bits 11:10 are the prescaler code.

  Written control fields read back in place. Bit 0 and all other bits read 0.
- R3: One tick lasts 2^S clocks. S is `PRE_SHIFT0` for prescaler code 0, `PRE_BASE` for code 1, `PRE_BASE+3` for code 2 and `PRE_BASE+8` for code 3. The interrupt flag (bit 3) reads 1 exactly 2^(`IVL_BASE`+2*interval code) ticks after the write that started the count.
- R4: `irq_o` is high while both the interrupt flag and interrupt enable are set. The flag is set on expiry even when interrupt enable is clear.
- R5: `RST_DELAY` ticks after the interrupt flag is set, with reset enable (bit 1) set, `rst_req_o` is high for exactly one cycle and the reset flag (bit 2) becomes 1. With reset enable clear, no request is made and the reset flag stays 0.
- R6: A write with bit 7 and bit 0 both set restarts the count from zero. The full timeout is then measured from that write.
- R7: The two flags are write-1-to-clear. Writing 0 to a flag bit leaves it unchanged.
- R8: Writing bit 7 as 0 stops and clears the count and any pending stage. After that no flag is set and no reset is requested, and already-latched flags keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Writes `wdata` to the control word this cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Current control and status word |
| irq_o | output | 1 | Pre-timeout interrupt |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The checker watches every cycle for these rules:
- the reset request lasts a single cycle;
- the request appears only with reset enable and run enable set on the previous cycle;
- the reset flag is present whenever the request is;
- the interrupt flag rises only while the timer is running;
- a flag falls only after a write of 1 to its bit.

The exact expiry cycle for every prescaler and interval pair, the restart that moves the deadline, and the stop that keeps latched flags can only be shown by the bench's timed scenarios.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int B_RESTART  = 0;
   localparam int B_RST_EN   = 1;
   localparam int B_RST_FLAG = 2;
   localparam int B_IRQ_FLAG = 3;
   localparam int B_IVL_LO   = 4;
   localparam int B_IRQ_EN   = 6;
   localparam int B_RUN      = 7;
   localparam int B_PRE_LO   = 10;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_COUNT = 2'd1,
      ST_WARN  = 2'd2,
      ST_DONE  = 2'd3
   } wd_stage_e;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
   parameter int PRE_SHIFT0 = 0,
   parameter int PRE_BASE   = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       clear,
   input  logic [1:0] sel,
   output logic       tick
);
   localparam int SH_MAX = PRE_BASE + 8;
   localparam int PRE_W  = (SH_MAX > 0) ? SH_MAX : 1;

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;
   int               shift;

   always_comb begin
      case (sel)
         2'd0:    shift = PRE_SHIFT0;
         2'd1:    shift = PRE_BASE;
         2'd2:    shift = PRE_BASE + 3;
         default: shift = PRE_BASE + 8;
      endcase
      mask = (PRE_W'(1) << shift) - PRE_W'(1);
   end

   assign tick = run && !clear && ((pre_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pre_q <= '0;
      else if (clear || !run)  pre_q <= '0;
      else                     pre_q <= pre_q + PRE_W'(1);
   end
endmodule

// File: rtl/wdog_seq.sv
module wdog_seq
   import wdog_pkg::*;
#(
   parameter int IVL_BASE  = 10,
   parameter int RST_DELAY = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       restart,
   input  logic       stop,
   input  logic       tick,
   input  logic [1:0] ivl,
   output logic       expire,
   output logic       bite
);
   localparam int IVL_W = IVL_BASE + 7;
   localparam int DLY_W = $clog2(RST_DELAY + 1);
   localparam int CNT_W = (IVL_W > DLY_W) ? IVL_W : DLY_W;

   wd_stage_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim_m1;
   logic             halt;

   assign lim_m1 = (CNT_W'(1) << (IVL_BASE + 2 * int'(ivl))) - CNT_W'(1);
   assign halt   = stop || (!run && !restart);

   assign expire = tick && !halt && !restart && (st_q == ST_COUNT) && (cnt_q == lim_m1);
   assign bite   = tick && !halt && !restart && (st_q == ST_WARN)
                   && (cnt_q == CNT_W'(RST_DELAY - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else if (halt) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else if (restart) begin
         st_q  <= ST_COUNT;
         cnt_q <= '0;
      end else if (tick) begin
         case (st_q)
            ST_COUNT: begin
               if (expire) begin st_q <= ST_WARN; cnt_q <= '0; end
               else        cnt_q <= cnt_q + CNT_W'(1);
            end
            ST_WARN: begin
               if (bite) begin st_q <= ST_DONE; cnt_q <= '0; end
               else      cnt_q <= cnt_q + CNT_W'(1);
            end
            default: cnt_q <= '0;
         endcase
      end
   end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdog_pkg::*;
#(
   parameter int PRE_SHIFT0 = 0,
   parameter int PRE_BASE   = 4,
   parameter int IVL_BASE   = 10,
   parameter int RST_DELAY  = 1024
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        irq_o,
   output logic        rst_req_o
);
   if (PRE_SHIFT0 < 0 || PRE_SHIFT0 > PRE_BASE) begin : g_bad_pre
      $error("PRE_SHIFT0 must lie in 0..PRE_BASE");
   end
   if (IVL_BASE < 0 || IVL_BASE > 20) begin : g_bad_ivl
      $error("IVL_BASE out of range");
   end
   if (RST_DELAY < 1) begin : g_bad_dly
      $error("RST_DELAY must be at least 1");
   end

   logic       run_q, ie_q, re_q, iflag_q, rflag_q, rst_q;
   logic [1:0] ivl_q, pre_q;
   logic       restart_now, stop_now, tick, expire, bite;

   assign restart_now = wr_en && wdata[B_RUN] && (wdata[B_RESTART] || !run_q);
   assign stop_now    = wr_en && !wdata[B_RUN];

   wdog_prescale #(.PRE_SHIFT0(PRE_SHIFT0), .PRE_BASE(PRE_BASE)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run_q), .clear(restart_now || stop_now),
      .sel(pre_q), .tick(tick)
   );

   wdog_seq #(.IVL_BASE(IVL_BASE), .RST_DELAY(RST_DELAY)) u_seq (
      .clk(clk), .rst_n(rst_n), .run(run_q), .restart(restart_now),
      .stop(stop_now), .tick(tick), .ivl(ivl_q), .expire(expire), .bite(bite)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0; ie_q <= 1'b0; re_q <= 1'b0;
         ivl_q <= 2'd0; pre_q <= 2'd0;
      end else if (wr_en) begin
         run_q <= wdata[B_RUN];
         ie_q  <= wdata[B_IRQ_EN];
         re_q  <= wdata[B_RST_EN];
         ivl_q <= wdata[B_IVL_LO +: 2];
         pre_q <= wdata[B_PRE_LO +: 2];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iflag_q <= 1'b0;
         rflag_q <= 1'b0;
         rst_q   <= 1'b0;
      end else begin
         iflag_q <= (iflag_q && !(wr_en && wdata[B_IRQ_FLAG])) || expire;
         rflag_q <= (rflag_q && !(wr_en && wdata[B_RST_FLAG])) || (bite && re_q);
         rst_q   <= bite && re_q;
      end
   end

   always_comb begin
      rdata                  = '0;
      rdata[B_RUN]           = run_q;
      rdata[B_IRQ_EN]        = ie_q;
      rdata[B_IVL_LO +: 2]   = ivl_q;
      rdata[B_IRQ_FLAG]      = iflag_q;
      rdata[B_RST_FLAG]      = rflag_q;
      rdata[B_RST_EN]        = re_q;
      rdata[B_PRE_LO +: 2]   = pre_q;
   end

   assign irq_o     = iflag_q && ie_q;
   assign rst_req_o = rst_q;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [31:0] wdata,
   input logic [31:0] rdata,
   input logic        irq_o,
   input logic        rst_req_o
);
   AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> !rst_req_o);                                   // R5
   AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> ($past(rdata[1]) && $past(rdata[7])));         // R5
   AST_RST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> rdata[2]);                                     // R5
   AST_IFLAG_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdata[3]) |-> $past(rdata[7]));                        // R3
   AST_IFLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdata[3]) |-> $past(wr_en && wdata[3]));               // R7
   AST_RFLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdata[2]) |-> $past(wr_en && wdata[2]));               // R7
   AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> (rdata[3] && rdata[6]));                    // R4
endmodule

bind wdog_timer wdog_checker u_wdog_checker (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
   .rdata(rdata), .irq_o(irq_o), .rst_req_o(rst_req_o)
);

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
   localparam int PS0 = 0, PB = 1, IB = 0, DLY = 4;

   logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_o, rst_req_o;
   int          errors = 0, checks = 0, cyc = 0;

   always #5 clk = ~clk;

   wdog_timer #(.PRE_SHIFT0(PS0), .PRE_BASE(PB), .IVL_BASE(IB), .RST_DELAY(DLY)) i_wdog_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
      .rdata(rdata), .irq_o(irq_o), .rst_req_o(rst_req_o)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++; checks++;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] v);
      @(negedge clk); wr_en = 1'b1; wdata = v;
      @(posedge clk); #1; wr_en = 1'b0; wdata = '0;
   endtask

   function automatic int tick_len(input int p);
      case (p)
         0: return 1 << PS0;
         1: return 1 << PB;
         2: return 1 << (PB + 3);
         default: return 1 << (PB + 8);
      endcase
   endfunction

   function automatic logic [31:0] cfg(input int p, input int i, input bit ie, input bit re, input bit rs);
      return (32'(p) << 10) | 32'h80 | (32'(ie) << 6) | (32'(i) << 4) | (32'(re) << 1) | 32'(rs);
   endfunction

   task automatic step();
      @(posedge clk); #1;
   endtask

   int first_irq, first_rst, rst_cnt;

   task automatic observe(input int n);
      first_irq = 0; first_rst = 0; rst_cnt = 0;
      for (int k = 1; k <= n; k++) begin
         step();
         if (rdata[3] && first_irq == 0) first_irq = k;
         if (rst_req_o) begin
            rst_cnt++;
            if (first_rst == 0) first_rst = k;
         end
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check("R1 rdata", rdata, 0);
      check("R1 irq", irq_o, 0);
      check("R1 rst", rst_req_o, 0);
      rst_n = 1'b1;
      step();

      // R2 field positions, restart bit reads 0, unused bits read 0
      wr(32'hFFFF_FF7F);
      check("R2 readback", rdata, 32'h0000_0C72);
      wr(32'h0);
      check("R2 cleared", rdata, 0);

      // R3 sweep of every prescaler/interval pair, R4 irq with enable
      for (int p = 0; p < 4; p++) begin
         for (int i = 0; i < 4; i++) begin
            int exp_n;
            exp_n = (1 << (IB + 2 * i)) * tick_len(p);
            wr(cfg(p, i, 1'b1, 1'b0, 1'b1));
            first_irq = 0;
            for (int k = 1; k <= exp_n + 2 && first_irq == 0; k++) begin
               step();
               if (rdata[3]) first_irq = k;
            end
            check($sformatf("R3 expiry p=%0d i=%0d", p, i), first_irq, exp_n);
            check("R4 irq with enable", irq_o, 1);
            wr(32'h0000_0008);
            check("R7 flag cleared by write 1", rdata[3], 0);
         end
      end

      // R4 flag without interrupt enable
      wr(cfg(0, 0, 1'b0, 1'b0, 1'b1));
      step();
      check("R4 flag set ie=0", rdata[3], 1);
      check("R4 irq stays low", irq_o, 0);
      wr(32'h0000_0008);

      // R5 reset request with reset enable: irq at 8, reset at (4+4)*2=16
      wr(cfg(1, 1, 1'b1, 1'b1, 1'b1));
      observe(24);
      check("R5 irq cycle", first_irq, 8);
      check("R5 reset cycle", first_rst, 16);
      check("R5 reset pulse width", rst_cnt, 1);
      check("R5 reset flag", rdata[2], 1);

      // R7 writing 0 to flags keeps them; writing 1 to bit 2 clears only it
      wr(cfg(1, 1, 1'b1, 1'b1, 1'b0));
      check("R7 flags kept", rdata[3:2], 2'b11);
      wr(cfg(1, 1, 1'b1, 1'b1, 1'b0) | 32'h4);
      check("R7 reset flag cleared only", rdata[3:2], 2'b10);
      wr(32'h0000_000C);

      // R5 no request with reset enable clear
      wr(cfg(1, 1, 1'b1, 1'b0, 1'b1));
      observe(24);
      check("R5 no request re=0", rst_cnt, 0);
      check("R5 no reset flag re=0", rdata[2], 0);
      wr(32'h0000_000C);

      // R6 restart moves the deadline
      wr(cfg(1, 1, 1'b1, 1'b0, 1'b1));
      repeat (5) step();
      wr(cfg(1, 1, 1'b1, 1'b0, 1'b1));
      observe(12);
      check("R6 expiry after restart", first_irq, 8);
      wr(32'h0000_000C);

      // R8 stop keeps latched flags and ends the sequence
      wr(cfg(0, 0, 1'b1, 1'b1, 1'b1));
      observe(8);
      check("R8 setup flags", rdata[3:2], 2'b11);
      wr(cfg(1, 2, 1'b1, 1'b1, 1'b1));
      repeat (5) step();
      wr(32'h0000_0000);
      observe(100);
      check("R8 no request after stop", rst_cnt, 0);
      check("R8 flags retained", rdata[3:2], 2'b11);
      check("R8 run bit reads 0", rdata[7], 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule